// File: doc/BRIEF.md
# B3ZS Line Decoder with Violation and Signal-Loss Alarms

This block sits behind the slicer and clock recovery of a DS3 receiver. In each cycle of the recovered line clock it samples two unipolar rails. One rail carries positive marks and the other carries negative marks. The block turns them into a single NRZ data stream and raises two alarms: a one-cycle coding-violation pulse and an active-low loss-of-signal flag.

The decoder tracks the polarity of the last ordinary mark and counts how many ordinary (bipolar-conforming) marks have arrived since the last polarity violation. A violation is accepted as a zero substitution only if two conditions hold. The first is its context: either two spaces in front of it, or a space in front of it preceded by an ordinary mark of the same polarity. The second is that an odd number of ordinary marks has arrived since the previous violation. An accepted substitution is replaced by three zeros while those bits are still inside a short alignment pipeline. Every other irregularity is flagged. The loss-of-signal flag is driven by a saturating counter of slots that carry no mark.

Top module: `b3zs_rx_decoder`

## Requirements
- R1: Both rails are sampled on the rising clock edge. A mark on either rail, or on both, decodes as 1 and an empty slot decodes as 0. The bit of the slot sampled at edge n is on data_o after edge n+2, which gives a three-edge latency.
- R2: A slot is a 00V substitution if it holds a mark whose polarity equals the last ordinary mark and the two slots before it are empty. The number of ordinary marks since the previous violation must be odd, or there must be no earlier violation since reset. Such a slot and the two empty slots before it decode as 000, and cv_o stays low.
- R3: A B0V substitution is an ordinary mark, then an empty slot, then a mark of the same polarity, with an odd number of ordinary marks since the previous violation (counting the B) or no earlier violation since reset. All three slots decode as 000, and cv_o stays low.
- R4: A same-polarity mark that meets neither R2 nor R3 decodes as 1. It raises cv_o for exactly the one cycle that follows the edge that sampled it.
- R5: A slot with both rails high decodes as 1 and raises cv_o. It does not change the polarity reference or the ordinary-mark count.
- R6: The first single-rail mark after reset sets the polarity reference and never raises cv_o.
- R7: The third consecutive empty slot raises cv_o once, and further empty slots in the same run raise nothing more. Empty slots before the first mark after reset raise nothing.
- R8: los_no goes low after the edge that samples the 128th consecutive slot without a mark. It stays high while the run is 127 slots or shorter.
- R9: los_no returns high after the edge that samples the first mark of any kind.
- R10: While reset is held, data_o and cv_o are 0 and los_no is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered line clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| data_o | output | 1 | Decoded NRZ data, three-edge latency |
| cv_o | output | 1 | One-cycle coding-violation pulse |
| los_no | output | 1 | Loss of signal, active low |

## Verification
A mark with both rails high, arriving after a silence of at least 128 slots, makes two things happen in the same cycle: it ends the loss-of-signal alarm and it is itself a coding violation. The bench holds the rails empty for 128 slots, confirms los_no is still high after 127 and low after 128, and then sends a both-rails mark. After the edge that samples that mark, it expects cv_o high and los_no high together. The same run also checks that a single zero-run pulse was raised during the silence and that the mark decodes as 1 three edges later.

// File: rtl/b3zs_pkg.sv
`timescale 1ns/1ps
package b3zs_pkg;
  // Number of line slots replaced by one zero substitution
  localparam int unsigned SUB_LEN = 3;
  // Empty-slot run that counts as an illegal zero run
  localparam int unsigned ZRUN_MAX = 3;
  localparam int unsigned ZRUN_W = $clog2(ZRUN_MAX + 1);

  typedef struct packed {
    logic p;
    logic n;
  } rail_t;
endpackage

// File: rtl/b3zs_classify.sv
`timescale 1ns/1ps
module b3zs_classify
  import b3zs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t rail_i,
  output logic  mark_o,
  output logic  sub_o,
  output logic  cv_o
);
  logic last_pol_q, last_pol_d;
  logic pol_vld_q, pol_vld_d;
  logic b_odd_q, b_odd_d;
  logic v_seen_q, v_seen_d;
  logic [1:0] h_mark_q, h_mark_d;
  logic [1:0] h_b_q, h_b_d;
  logic [1:0] h_pol_q, h_pol_d;
  logic [ZRUN_W-1:0] zrun_q, zrun_d;
  logic cv_q, cv_d;

  logic single, dbl, pol, viol, ctx00, ctxb0, par_ok, b_now, zero_err;

  always_comb begin
    single   = rail_i.p ^ rail_i.n;
    dbl      = rail_i.p & rail_i.n;
    mark_o   = rail_i.p | rail_i.n;
    pol      = rail_i.n;
    viol     = single & pol_vld_q & (pol == last_pol_q);
    ctx00    = ~h_mark_q[0] & ~h_mark_q[1];
    ctxb0    = ~h_mark_q[0] & h_b_q[1] & (h_pol_q[1] == pol);
    par_ok   = ~v_seen_q | b_odd_q;
    sub_o    = viol & (ctx00 | ctxb0) & par_ok;
    b_now    = single & ~viol;
    zero_err = ~mark_o & (zrun_q == ZRUN_W'(ZRUN_MAX - 1));
    cv_d     = dbl | (viol & ~sub_o) | zero_err;

    last_pol_d = last_pol_q;
    pol_vld_d  = pol_vld_q;
    b_odd_d    = b_odd_q;
    v_seen_d   = v_seen_q;
    if (b_now) begin
      last_pol_d = pol;
      pol_vld_d  = 1'b1;
      b_odd_d    = ~b_odd_q;
    end
    if (viol) begin
      b_odd_d  = 1'b0;
      v_seen_d = 1'b1;
    end
    h_mark_d = {h_mark_q[0], mark_o};
    h_b_d    = {h_b_q[0], b_now};
    h_pol_d  = {h_pol_q[0], pol};
    if (mark_o)
      zrun_d = '0;
    else if (zrun_q != ZRUN_W'(ZRUN_MAX))
      zrun_d = zrun_q + 1'b1;
    else
      zrun_d = zrun_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pol_q <= 1'b0;
      pol_vld_q  <= 1'b0;
      b_odd_q    <= 1'b0;
      v_seen_q   <= 1'b0;
      h_mark_q   <= '0;
      h_b_q      <= '0;
      h_pol_q    <= '0;
      zrun_q     <= ZRUN_W'(ZRUN_MAX);
      cv_q       <= 1'b0;
    end else begin
      last_pol_q <= last_pol_d;
      pol_vld_q  <= pol_vld_d;
      b_odd_q    <= b_odd_d;
      v_seen_q   <= v_seen_d;
      h_mark_q   <= h_mark_d;
      h_b_q      <= h_b_d;
      h_pol_q    <= h_pol_d;
      zrun_q     <= zrun_d;
      cv_q       <= cv_d;
    end
  end

  assign cv_o = cv_q;

  // R2 / R3: an accepted substitution never produces a violation pulse
  a_r3_sub_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o |=> !cv_q);
  // R6: the mark that establishes the polarity reference is never flagged
  a_r6_first_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pol_vld_q && (rail_i.p ^ rail_i.n)) |=> !cv_q);
endmodule

// File: rtl/b3zs_align.sv
`timescale 1ns/1ps
module b3zs_align #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic clear_i,
  output logic bit_o
);
  logic [DEPTH-1:0] stg_q, stg_d;

  always_comb begin
    if (clear_i) stg_d = '0;
    else         stg_d = {stg_q[DEPTH-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign bit_o = stg_q[DEPTH-1];
endmodule

// File: rtl/b3zs_los.sv
`timescale 1ns/1ps
module b3zs_los #(
  parameter int unsigned LIMIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic los_no
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic los_n_q, los_n_d;

  always_comb begin
    if (mark_i)
      cnt_d = '0;
    else if (cnt_q != CW'(LIMIT))
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
    los_n_d = (cnt_d != CW'(LIMIT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      los_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      los_n_q <= los_n_d;
    end
  end

  assign los_no = los_n_q;

  // R9: any sampled mark ends the alarm
  a_r9_mark_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |=> los_n_q);
  // R8: once raised, the alarm holds while the line stays empty
  a_r8_alarm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!los_n_q && !mark_i) |=> !los_n_q);
endmodule

// File: rtl/b3zs_rx_decoder.sv
`timescale 1ns/1ps
module b3zs_rx_decoder
  import b3zs_pkg::*;
#(
  parameter int unsigned LOS_LIMIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic data_o,
  output logic cv_o,
  output logic los_no
);
  logic [1:0] rst_sync_q;
  logic rst_q;
  logic mark, sub;
  rail_t rail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign rail.p = pos_i;
  assign rail.n = neg_i;

  b3zs_classify u_classify (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .rail_i (rail),
    .mark_o (mark),
    .sub_o  (sub),
    .cv_o   (cv_o)
  );

  b3zs_align #(.DEPTH(SUB_LEN)) u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .bit_i   (mark),
    .clear_i (sub),
    .bit_o   (data_o)
  );

  b3zs_los #(.LIMIT(LOS_LIMIT)) u_los (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .mark_i (mark),
    .los_no (los_no)
  );

  // R2 / R3: the substituted slots leave the pipeline as three zeros
  a_r2_sub_zeroes: assert property (@(posedge clk_i) disable iff (!rst_q)
    sub |=> !data_o ##1 !data_o ##1 !data_o);
  // R5: a both-rails slot is always flagged
  a_r5_dbl_flag: assert property (@(posedge clk_i) disable iff (!rst_q)
    (pos_i && neg_i) |=> cv_o);
endmodule

// File: tb/b3zs_rx_decoder_tb.sv
`timescale 1ns/1ps
module b3zs_rx_decoder_tb;
  typedef struct {
    bit    care;
    bit    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos = 1'b0;
  logic neg = 1'b0;
  logic data_o, cv_o, los_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  exp_t dq[$];
  exp_t cq[$];

  always #10 clk = ~clk;

  b3zs_rx_decoder u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pos_i  (pos),
    .neg_i  (neg),
    .data_o (data_o),
    .cv_o   (cv_o),
    .los_no (los_no)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: cv for the slot sampled at this edge, data for the slot two edges older
  always @(posedge clk) begin
    #5;
    if (cq.size() > 0) begin
      exp_t c;
      c = cq.pop_front();
      if (c.care) check(c.tag, "cv_o", cv_o, c.val);
    end
    if (dq.size() == 3) begin
      exp_t d;
      d = dq.pop_front();
      if (d.care) check(d.tag, "data_o", data_o, d.val);
    end
  end

  task automatic send(input bit p, input bit n, input byte dch, input byte cch, input string tag);
    exp_t d, c;
    @(negedge clk);
    pos = p;
    neg = n;
    d.care = (dch != "x"); d.val = (dch == "1"); d.tag = tag;
    c.care = (cch != "x"); c.val = (cch == "1"); c.tag = tag;
    dq.push_back(d);
    cq.push_back(c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    pos = 1'b0;
    neg = 1'b0;
    rst_n = 1'b0;
    dq.delete();
    cq.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // rails: P positive, N negative, D both, 0 empty; expectations 0/1/x
  task automatic run_vec(input string tag, input string rails, input string dexp, input string cexp);
    do_reset();
    for (int i = 0; i < rails.len(); i++) begin
      byte r;
      r = rails[i];
      send(r == "P" || r == "D", r == "N" || r == "D", dexp[i], cexp[i], tag);
    end
    repeat (3) send(1'b0, 1'b0, "x", "x", tag);
    dq.delete();
    cq.delete();
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: outputs held while reset is asserted, even with activity on the rails
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pos = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "data_o", data_o, 1'b0);
    check("R10", "cv_o", cv_o, 1'b0);
    check("R10", "los_no", los_no, 1'b1);
    pos = 1'b0;

    run_vec("R1 alternation",     "PNP0N",     "11101",     "00000");
    run_vec("R2 00V",             "PN00NP00P", "110001000", "000000000");
    run_vec("R3 B0V",             "PN00NP0PN", "110000001", "000000000");
    run_vec("R4 even-count V",    "PN00N00NP", "110000011", "000000010");
    run_vec("R4 R6 no context",   "NPP",       "111",       "001");
    run_vec("R5 both rails",      "PDNP",      "1111",      "0100");
    run_vec("R7 zero run",        "P0000N",    "100001",    "000100");
    run_vec("R7 idle after reset","0000PN",    "000011",    "000000");

    // R8 / R9 with a both-rails mark ending the silence
    do_reset();
    send(1'b1, 1'b0, "1", "0", "R8 lead mark");
    for (int i = 1; i <= 128; i++) begin
      send(1'b0, 1'b0, "0", (i == 3) ? "1" : "0", "R8 R7 silence");
    end
    check("R8 at 127", "los_no", los_no, 1'b1);
    send(1'b1, 1'b1, "1", "1", "R5 R9 both rails ends silence");
    check("R8 at 128", "los_no", los_no, 1'b0);
    send(1'b0, 1'b0, "0", "0", "R9 trailer");
    check("R9 cleared", "los_no", los_no, 1'b1);
    repeat (3) send(1'b0, 1'b0, "x", "x", "R9 flush");
    dq.delete();
    cq.delete();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule